// File: doc/BRIEF.md
# RGMII 100 Mbit/s Receive Deframer

This block sits directly behind the receive side of an RGMII PHY running at 100 Mbit/s. In that mode the PHY supplies a 25 MHz clock and a 4-bit data bus that is sampled on the rising edge only. A control line marks the frame: it goes high at the start of the frame and low at the end. The deframer searches the incoming nibbles for the end of the preamble and then pairs nibbles into bytes, low nibble first. It passes every frame byte onward, including the four trailing CRC bytes, so the MAC above can still see them. It also marks the first byte and the end of the frame.

Several results are produced alongside the byte stream. The block pulls the destination address, source address and length/type out of the first fourteen bytes. It runs the reflected Ethernet CRC-32 over the whole frame and reports a bad residue with the end-of-frame pulse. It also flags a frame that ends on half a byte. Between frames the PHY places link information on the data lines, and the block keeps the most recent value as link up, speed and duplex outputs.

Top module: `rgmii_nib_rx`

## Requirements
- R1: On every rising clock edge where `rx_ctl` is sampled low, the nibble on `rx_d` is latched into the link outputs one cycle later: `link_up` = bit 0, `link_speed` = bits 2:1, `link_duplex` = bit 3. When `rx_ctl` is sampled high, the link outputs hold their value.
- R2: Byte output starts only after a nibble 0x5 is followed directly by a nibble 0xD, both sampled with `rx_ctl` high. No preamble or delimiter nibble ever appears as a byte. A 0xD that follows any other nibble does not start a frame.
- R3: After the delimiter, nibbles are paired in arrival order. The first nibble of each pair becomes bits 3:0 of `byte_data` and the second becomes bits 7:4.
- R4: Each assembled byte is shown for exactly one cycle with `byte_vld` high, starting the cycle after its second nibble is sampled. Every byte of the frame up to the falling edge of `rx_ctl` is delivered, including the 4 CRC bytes. `sof` is high together with `byte_vld` for the first byte of a frame only.
- R5: `eof` pulses for one cycle, in the cycle after the first edge at which `rx_ctl` is sampled low during a frame. It never coincides with `byte_vld`.
- R6: `crc_err` is high only during `eof`. It is set when the CRC-32 (polynomial 0x04C11DB7, reflected, initial value all ones, no final inversion) over all frame bytes, including the CRC field, does not leave the bit-reversed residue 0xC704DD7B.
- R7: `frame_err` is high only during `eof`. It is set when an odd number of nibbles followed the delimiter.
- R8: Frame bytes 0–5 appear on `dst_mac`, bytes 6–11 on `src_mac` and bytes 12–13 on `eth_type`, with the first byte on the wire in the most significant position. `hdr_vld` pulses once, one cycle after byte 13 is presented, and the fields hold until the next frame overwrites them.
- R9: Nibbles sampled while `rx_ctl` is low never produce `byte_vld` or `eof`, and they clear any partial delimiter match.
- R10: A burst with `rx_ctl` high that contains no delimiter produces no byte, no `sof` and no `eof`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | 25 MHz receive clock from the PHY |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_ctl | input | 1 | Receive control: data valid |
| rx_d | input | 4 | Receive data nibble |
| byte_vld | output | 1 | Frame byte strobe |
| byte_data | output | 8 | Frame byte |
| sof | output | 1 | First byte of a frame |
| eof | output | 1 | End-of-frame pulse |
| crc_err | output | 1 | Bad CRC residue, valid with eof |
| frame_err | output | 1 | Odd nibble count, valid with eof |
| hdr_vld | output | 1 | Header fields complete |
| dst_mac | output | 48 | Destination address |
| src_mac | output | 48 | Source address |
| eth_type | output | 16 | Length/type field |
| link_up | output | 1 | Link status from the gap nibble |
| link_speed | output | 2 | Speed code from the gap nibble |
| link_duplex | output | 1 | Duplex from the gap nibble |

## Verification
At the edge where `rx_ctl` is first sampled low, two things happen together: the end-of-frame pulse is produced, and the first gap nibble is captured as link status. To exercise this, each frame is preceded by a gap that carries the bitwise inverse of the status that follows it. The bench records the link outputs in the cycle where `eof` is seen and requires them to already show the new status. It also requires that `crc_err` and `frame_err` in that same cycle reflect the frame that just ended. A second test places the last byte strobe directly before the end pulse and checks that the two never share a cycle.

// File: rtl/rgmii_rx_pkg.sv
package rgmii_rx_pkg;
    localparam int NIB_W      = 4;
    localparam int BYTE_W     = 2 * NIB_W;
    localparam int MAC_BYTES  = 6;
    localparam int TYPE_BYTES = 2;
    localparam int HDR_BYTES  = 2 * MAC_BYTES + TYPE_BYTES;
    localparam int MAC_W      = MAC_BYTES * BYTE_W;
    localparam int TYPE_W     = TYPE_BYTES * BYTE_W;
    localparam int CRC_W      = 32;
    localparam int SPEED_W    = 2;

    localparam logic [NIB_W-1:0] PRE_NIB = 4'h5;
    localparam logic [NIB_W-1:0] SFD_NIB = 4'hD;
    localparam logic [CRC_W-1:0] CRC_POLY_REFL = 32'hEDB88320;
    localparam logic [CRC_W-1:0] CRC_RESIDUE   = 32'hC704DD7B;

    typedef enum logic {ST_HUNT, ST_DATA} rx_st_e;
endpackage

// File: rtl/rgmii_rx_align.sv
module rgmii_rx_align
    import rgmii_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rx_ctl,
    input  logic [NIB_W-1:0]  rx_d,
    output logic              byte_vld,
    output logic [BYTE_W-1:0] byte_data,
    output logic              sof,
    output logic              eof,
    output logic              frame_err,
    output logic              sfd_hit,
    output logic [NIB_W-1:0]  link_stat
);
    typedef struct packed {
        rx_st_e             st;
        logic               prev5;
        logic               half;
        logic               first;
        logic [NIB_W-1:0]   lo;
        logic               vld;
        logic [BYTE_W-1:0]  data;
        logic               sof;
        logic               eof;
        logic               ferr;
        logic               sfd;
        logic [NIB_W-1:0]   stat;
    } align_s;

    align_s r_q, r_d;

    always_comb begin
        r_d      = r_q;
        r_d.vld  = 1'b0;
        r_d.sof  = 1'b0;
        r_d.eof  = 1'b0;
        r_d.ferr = 1'b0;
        r_d.sfd  = 1'b0;
        if (!rx_ctl) begin
            r_d.stat  = rx_d;
            r_d.prev5 = 1'b0;
            r_d.half  = 1'b0;
            if (r_q.st == ST_DATA) begin
                r_d.eof  = 1'b1;
                r_d.ferr = r_q.half;
            end
            r_d.st = ST_HUNT;
        end else if (r_q.st == ST_HUNT) begin
            if (r_q.prev5 && (rx_d == SFD_NIB)) begin
                r_d.st    = ST_DATA;
                r_d.half  = 1'b0;
                r_d.first = 1'b1;
                r_d.sfd   = 1'b1;
            end
            r_d.prev5 = (rx_d == PRE_NIB);
        end else begin
            if (!r_q.half) begin
                r_d.lo   = rx_d;
                r_d.half = 1'b1;
            end else begin
                r_d.data  = {rx_d, r_q.lo};
                r_d.vld   = 1'b1;
                r_d.sof   = r_q.first;
                r_d.first = 1'b0;
                r_d.half  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign byte_vld  = r_q.vld;
    assign byte_data = r_q.data;
    assign sof       = r_q.sof;
    assign eof       = r_q.eof;
    assign frame_err = r_q.ferr;
    assign sfd_hit   = r_q.sfd;
    assign link_stat = r_q.stat;
endmodule

// File: rtl/rgmii_rx_crc.sv
module rgmii_rx_crc
    import rgmii_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              en,
    input  logic [BYTE_W-1:0] din,
    output logic              match
);
    typedef struct packed {
        logic [CRC_W-1:0] crc;
    } crc_s;

    crc_s c_q, c_d;
    logic [CRC_W-1:0] rev;

    always_comb begin
        c_d = c_q;
        if (clr) begin
            c_d.crc = '1;
        end else if (en) begin
            for (int i = 0; i < BYTE_W; i++) begin
                if (c_d.crc[0] ^ din[i]) begin
                    c_d.crc = (c_d.crc >> 1) ^ CRC_POLY_REFL;
                end else begin
                    c_d.crc = c_d.crc >> 1;
                end
            end
        end
    end

    always_comb begin
        for (int i = 0; i < CRC_W; i++) begin
            rev[i] = c_q.crc[CRC_W-1-i];
        end
    end

    assign match = (rev == CRC_RESIDUE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            c_q.crc <= '1;
        end else begin
            c_q <= c_d;
        end
    end
endmodule

// File: rtl/rgmii_rx_hdr.sv
module rgmii_rx_hdr
    import rgmii_rx_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic              sof,
    input  logic [BYTE_W-1:0] byte_data,
    output logic [MAC_W-1:0]  dst_mac,
    output logic [MAC_W-1:0]  src_mac,
    output logic [TYPE_W-1:0] eth_type,
    output logic              hdr_vld
);
    localparam int CW = $clog2(HDR_BYTES + 1);

    typedef struct packed {
        logic [CW-1:0]     cnt;
        logic [MAC_W-1:0]  dst;
        logic [MAC_W-1:0]  src;
        logic [TYPE_W-1:0] typ;
        logic              hv;
    } hdr_s;

    hdr_s h_q, h_d;
    logic [CW-1:0] idx;

    always_comb begin
        h_d    = h_q;
        h_d.hv = 1'b0;
        idx    = sof ? '0 : h_q.cnt;
        if (byte_vld) begin
            if (idx < CW'(MAC_BYTES)) begin
                h_d.dst = {h_q.dst[MAC_W-BYTE_W-1:0], byte_data};
            end else if (idx < CW'(2 * MAC_BYTES)) begin
                h_d.src = {h_q.src[MAC_W-BYTE_W-1:0], byte_data};
            end else if (idx < CW'(HDR_BYTES)) begin
                h_d.typ = {h_q.typ[TYPE_W-BYTE_W-1:0], byte_data};
            end
            if (idx < CW'(HDR_BYTES)) begin
                h_d.cnt = idx + 1'b1;
            end
            h_d.hv = (idx == CW'(HDR_BYTES - 1));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            h_q <= '0;
        end else begin
            h_q <= h_d;
        end
    end

    assign dst_mac  = h_q.dst;
    assign src_mac  = h_q.src;
    assign eth_type = h_q.typ;
    assign hdr_vld  = h_q.hv;
endmodule

// File: rtl/rgmii_nib_rx.sv
module rgmii_nib_rx
    import rgmii_rx_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         rx_ctl,
    input  logic [3:0]   rx_d,
    output logic         byte_vld,
    output logic [7:0]   byte_data,
    output logic         sof,
    output logic         eof,
    output logic         crc_err,
    output logic         frame_err,
    output logic         hdr_vld,
    output logic [47:0]  dst_mac,
    output logic [47:0]  src_mac,
    output logic [15:0]  eth_type,
    output logic         link_up,
    output logic [1:0]   link_speed,
    output logic         link_duplex
);
    logic             sfd_hit;
    logic             crc_ok;
    logic [NIB_W-1:0] link_stat;

    rgmii_rx_align u_align (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_ctl    (rx_ctl),
        .rx_d      (rx_d),
        .byte_vld  (byte_vld),
        .byte_data (byte_data),
        .sof       (sof),
        .eof       (eof),
        .frame_err (frame_err),
        .sfd_hit   (sfd_hit),
        .link_stat (link_stat)
    );

    rgmii_rx_crc u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (sfd_hit),
        .en    (byte_vld),
        .din   (byte_data),
        .match (crc_ok)
    );

    rgmii_rx_hdr u_hdr (
        .clk       (clk),
        .rst_n     (rst_n),
        .byte_vld  (byte_vld),
        .sof       (sof),
        .byte_data (byte_data),
        .dst_mac   (dst_mac),
        .src_mac   (src_mac),
        .eth_type  (eth_type),
        .hdr_vld   (hdr_vld)
    );

    assign crc_err     = eof & ~crc_ok;
    assign link_up     = link_stat[0];
    assign link_speed  = link_stat[SPEED_W:1];
    assign link_duplex = link_stat[NIB_W-1];
endmodule

// File: rtl/rgmii_rx_chk.sv
module rgmii_rx_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       rx_ctl,
    input logic [3:0] rx_d,
    input logic       byte_vld,
    input logic       sof,
    input logic       eof,
    input logic       crc_err,
    input logic       frame_err,
    input logic       link_up,
    input logic [1:0] link_speed,
    input logic       link_duplex
);
    logic past_ok;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            past_ok <= 1'b0;
        end else begin
            past_ok <= 1'b1;
        end
    end

    p_status_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(rx_ctl)) |->
        (link_up == $past(rx_d[0]) && link_speed == $past(rx_d[2:1]) && link_duplex == $past(rx_d[3])));

    p_status_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && $past(rx_ctl)) |-> ($stable(link_up) && $stable(link_speed) && $stable(link_duplex)));

    p_sof_with_byte_r4: assert property (@(posedge clk) disable iff (!rst_n)
        sof |-> byte_vld);

    p_eof_alone_r5: assert property (@(posedge clk) disable iff (!rst_n)
        eof |-> !byte_vld);

    p_eof_after_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && eof) |-> !$past(rx_ctl));

    p_crc_flag_at_eof_r6: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |-> eof);

    p_odd_flag_at_eof_r7: assert property (@(posedge clk) disable iff (!rst_n)
        frame_err |-> eof);

    p_no_byte_in_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && !$past(rx_ctl)) |-> !byte_vld);
endmodule

bind rgmii_nib_rx rgmii_rx_chk u_chk (.*);

// File: tb/sim_rgmii_nib_rx.sv
module sim_rgmii_nib_rx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx_ctl = 1'b0;
    logic [3:0]  rx_d = 4'h0;
    logic        byte_vld, sof, eof, crc_err, frame_err, hdr_vld;
    logic [7:0]  byte_data;
    logic [47:0] dst_mac, src_mac;
    logic [15:0] eth_type;
    logic        link_up, link_duplex;
    logic [1:0]  link_speed;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rgmii_nib_rx u0 (.*);

    // monitor state
    logic [7:0]  rxb [0:127];
    int          rxn, sofcnt, sofpos, eofcnt, hdrcnt, eof_byte_clash;
    logic        m_crc, m_ferr;
    logic [3:0]  m_link;
    logic [47:0] m_dst, m_src;
    logic [15:0] m_typ;
    logic [7:0]  fr [0:127];

    task automatic clear_mon();
        rxn = 0; sofcnt = 0; sofpos = -1; eofcnt = 0; hdrcnt = 0; eof_byte_clash = 0;
        m_crc = 0; m_ferr = 0; m_link = 0; m_dst = 0; m_src = 0; m_typ = 0;
    endtask

    always @(negedge clk) begin
        if (rst_n) begin
            if (byte_vld) begin
                if (sof) begin sofcnt++; sofpos = rxn; end
                if (rxn < 128) rxb[rxn] = byte_data;
                rxn++;
            end
            if (eof) begin
                eofcnt++;
                m_crc = crc_err;
                m_ferr = frame_err;
                m_link = {link_duplex, link_speed, link_up};
                if (byte_vld) eof_byte_clash++;
            end
            if (hdr_vld) begin
                hdrcnt++;
                m_dst = dst_mac; m_src = src_mac; m_typ = eth_type;
            end
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic nib(input logic c, input logic [3:0] v);
        @(negedge clk);
        rx_ctl = c;
        rx_d = v;
    endtask

    function automatic logic [31:0] fcs_of(input int len);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int i = 0; i < len; i++) begin
            c = c ^ {24'h0, fr[i]};
            for (int b = 0; b < 8; b++) c = c[0] ? ((c >> 1) ^ 32'hEDB88320) : (c >> 1);
        end
        return ~c;
    endfunction

    task automatic send_frame(input int len, input int pre_n, input bit junk,
                              input bit corrupt, input bit odd, input logic [3:0] st);
        logic [31:0] fcs;
        logic [47:0] dst = 48'hDA0802030405;
        logic [47:0] src = 48'h5A0102030405;
        for (int i = 0; i < len; i++) begin
            if (i < 6)       fr[i] = dst[47-8*i -: 8];
            else if (i < 12) fr[i] = src[47-8*(i-6) -: 8];
            else if (i == 12) fr[i] = 8'hFF;
            else if (i == 13) fr[i] = 8'hFE;
            else             fr[i] = 8'(8'hFD - 8'(i - 14));
        end
        fcs = fcs_of(len);
        for (int k = 0; k < 4; k++) fr[len+k] = fcs[8*k +: 8];
        if (corrupt) fr[20] = fr[20] ^ 8'h01;
        clear_mon();
        for (int g = 0; g < 3; g++) nib(1'b0, ~st);
        if (junk) begin nib(1'b1, 4'hA); nib(1'b1, 4'hD); end
        for (int p = 0; p < pre_n; p++) nib(1'b1, 4'h5);
        nib(1'b1, 4'hD);
        for (int i = 0; i < len + 4; i++) begin
            nib(1'b1, fr[i][3:0]);
            nib(1'b1, fr[i][7:4]);
        end
        if (odd) nib(1'b1, 4'h3);
        for (int g = 0; g < 6; g++) nib(1'b0, st);
    endtask

    task automatic judge(input int len, input bit exp_crc, input bit exp_ferr, input logic [3:0] st);
        bit same = 1;
        chk(rxn == len + 4, "R4 byte count incl CRC", 64'(rxn), 64'(len + 4));
        for (int i = 0; i < len + 4 && i < rxn; i++) if (rxb[i] !== fr[i]) same = 0;
        chk(same, "R3 byte content low nibble first", 64'(rxb[0]), 64'(fr[0]));
        chk(sofcnt == 1 && sofpos == 0, "R4 sof on first byte", 64'(sofpos), 64'd0);
        chk(eofcnt == 1, "R5 one eof", 64'(eofcnt), 64'd1);
        chk(eof_byte_clash == 0, "R5 eof apart from byte", 64'(eof_byte_clash), 64'd0);
        chk(m_crc == exp_crc, "R6 crc_err", 64'(m_crc), 64'(exp_crc));
        chk(m_ferr == exp_ferr, "R7 frame_err", 64'(m_ferr), 64'(exp_ferr));
        chk(m_link == st, "R1 status at eof", 64'(m_link), 64'(st));
        chk(hdrcnt == 1 && m_dst == 48'hDA0802030405, "R8 dst_mac", m_dst, 64'hDA0802030405);
        chk(m_src == 48'h5A0102030405, "R8 src_mac", m_src, 64'h5A0102030405);
        chk(m_typ == 16'hFFFE, "R8 eth_type", 64'(m_typ), 64'hFFFE);
        chk({link_duplex, link_speed, link_up} == st, "R1 status held after gap",
            64'({link_duplex, link_speed, link_up}), 64'(st));
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        chk(byte_vld == 0 && eof == 0 && sof == 0, "R4 reset strobes low", 64'(byte_vld), 64'd0);
        chk(link_up == 0 && dst_mac == 0 && crc_err == 0, "R1 reset state", 64'(dst_mac), 64'd0);
        rst_n = 1'b1;

        // sweep all status codes across the normal length range
        for (int s = 0; s < 16; s++) begin
            send_frame(60 + (s % 5), 15, 0, 0, 0, 4'(s));
            judge(60 + (s % 5), 0, 0, 4'(s));
        end
        // R2 shortest preamble and a false delimiter
        send_frame(64, 1, 0, 0, 0, 4'h9);
        judge(64, 0, 0, 4'h9);
        send_frame(62, 3, 1, 0, 0, 4'h6);
        judge(62, 0, 0, 4'h6);
        // R6 corrupted payload
        send_frame(61, 15, 0, 1, 0, 4'hB);
        judge(61, 1, 0, 4'hB);
        // R7 trailing half byte
        send_frame(63, 15, 0, 0, 1, 4'h3);
        judge(63, 0, 1, 4'h3);

        // R10 / R9 burst without delimiter, gap 5 then D with valid low
        clear_mon();
        for (int g = 0; g < 3; g++) nib(1'b0, 4'h0);
        for (int p = 0; p < 20; p++) nib(1'b1, 4'h5);
        nib(1'b0, 4'h5);
        nib(1'b1, 4'hD);
        for (int p = 0; p < 4; p++) nib(1'b1, 4'h1);
        for (int g = 0; g < 6; g++) nib(1'b0, 4'h2);
        chk(rxn == 0 && sofcnt == 0, "R10 no bytes without delimiter", 64'(rxn), 64'd0);
        chk(eofcnt == 0, "R9 no eof outside frame", 64'(eofcnt), 64'd0);
        chk({link_duplex, link_speed, link_up} == 4'h2, "R1 gap status", 64'({link_duplex, link_speed, link_up}), 64'h2);

        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule